// File: doc/BRIEF.md
# SD-Card SPI Byte Exchange Engine

This block is the host side of an SPI link to an SD card in SPI mode. Software reaches it through four byte-wide registers. A write to the data register shifts that byte out on MOSI, most significant bit first, and at the same time shifts eight bits in from MISO. Software polls the busy bit in the status register with a sign test to learn when the exchange has finished. It then reads the received byte back from the data register.

SCK runs only while a byte is in flight and otherwise rests low. This lets the host leave any gap between bytes. The SCK half-period is set in system clocks by a divider register. After reset the divider holds its slowest setting, so the first exchanges during card start-up run at the lowest rate. The card chip select is an active-low output driven straight from a control bit. A write to the data register during an exchange is dropped and recorded in a sticky overrun flag.

The register map (`reg_addr`) is:
- 0: data
- 1: status (bit 7 busy, bit 6 overrun)
- 2: divider
- 3: control (bit 0 selects the card)

Top module: `sdspi_xfer`

## Requirements
- R1: A write to address 0 while idle starts an exchange of the written byte, and status bit 7 (busy) reads 1 from the cycle after the write edge.
- R2: With divider value D, busy stays 1 for exactly 16*(D+1) cycles after the write edge, and clears on the edge that completes the eighth SCK falling edge.
- R3: The transmit byte appears on MOSI most significant bit first (SPI mode 0). MOSI changes only where SCK falls or where an exchange starts, and MISO is sampled on each SCK rising edge.
- R4: Each exchange produces exactly eight SCK rising edges, and SCK is low whenever busy is 0.
- R5: Once busy clears, a read of address 0 returns the eight bits sampled from MISO, first-sampled bit in bit 7.
- R6: Address 2 holds the divider D (SCK half-period = D+1 system clocks) and resets to all ones.
- R7: `spi_cs_n` equals the inverse of control bit 0 (address 3) from the cycle after that register is written, whether or not an exchange is running. It resets to 1.
- R8: A write to address 0 while busy is 1 leaves the running exchange and its timing unchanged and sets status bit 6 (overrun), which then stays set.
- R9: A write to address 1 with bit 6 set clears the overrun flag.
- R10: After reset, busy and overrun read 0, the data register reads 0, and SCK is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected address |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Serial data to the card |
| spi_miso | input | 1 | Serial data from the card |
| spi_cs_n | output | 1 | Active-low card select |

## Verification
The exchange is driven from a table that pairs divider values from 0 to 7 with transmit and card-reply bytes. The patterns are alternating bits, all ones against all zeros, and single set bits at either end. These separate bit-order reversal, a stuck MOSI or MISO sample, and off-by-one errors in the half-period count. The bench checks the busy window one cycle before and at the expected end, so a late or early clear is caught. Directed tests then cover the reset divider, a write dropped during an exchange with its sticky flag and clear, and chip select toggled in the middle of a byte.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;
    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        RA_DATA = 2'd0,
        RA_STAT = 2'd1,
        RA_DIV  = 2'd2,
        RA_CTRL = 2'd3
    } reg_addr_e;

    localparam int STAT_BUSY_BIT = 7;
    localparam int STAT_OVR_BIT  = 6;
endpackage

// File: rtl/sdspi_clkdiv.sv
module sdspi_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == half);
        cnt_d = cnt_q;
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sdspi_shifter.sv
module sdspi_shifter
    import sdspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic [BYTE_W-1:0] rx_byte
);
    typedef struct packed {
        logic                 busy;
        logic                 sck;
        logic [BIT_CNT_W-1:0] cnt;
        logic [BYTE_W-1:0]    tx_sh;
        logic [BYTE_W-1:0]    rx_sh;
        logic [BYTE_W-1:0]    rx_hold;
    } sh_t;

    sh_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy  = 1'b1;
                s_d.sck   = 1'b0;
                s_d.cnt   = '0;
                s_d.tx_sh = tx_byte;
            end
        end else if (tick) begin
            if (!s_q.sck) begin
                // rising edge: sample the card
                s_d.sck   = 1'b1;
                s_d.rx_sh = {s_q.rx_sh[BYTE_W-2:0], miso};
            end else begin
                // falling edge: present the next bit
                s_d.sck   = 1'b0;
                s_d.tx_sh = {s_q.tx_sh[BYTE_W-2:0], 1'b0};
                s_d.cnt   = s_q.cnt + 1'b1;
                if (s_q.cnt == BIT_CNT_W'(BYTE_W - 1)) begin
                    s_d.busy    = 1'b0;
                    s_d.rx_hold = s_q.rx_sh;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign sck     = s_q.sck;
    assign mosi    = s_q.tx_sh[BYTE_W-1];
    assign rx_byte = s_q.rx_hold;
endmodule

// File: rtl/sdspi_xfer.sv
module sdspi_xfer
    import sdspi_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    localparam logic [DIV_W-1:0] DIV_SLOWEST = '1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             sel;
        logic             ovr;
    } regs_t;

    regs_t r_d, r_q;
    logic busy, tick, start;
    logic [BYTE_W-1:0] rx_byte;

    always_comb begin
        r_d   = r_q;
        start = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                RA_DATA: begin
                    if (busy) r_d.ovr = 1'b1;
                    else      start   = 1'b1;
                end
                RA_STAT: if (reg_wdata[STAT_OVR_BIT]) r_d.ovr = 1'b0;
                RA_DIV:  r_d.div = reg_wdata[DIV_W-1:0];
                default: r_d.sel = reg_wdata[0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{div: DIV_SLOWEST, sel: 1'b0, ovr: 1'b0};
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_DATA: reg_rdata = rx_byte;
            RA_STAT: begin
                reg_rdata[STAT_BUSY_BIT] = busy;
                reg_rdata[STAT_OVR_BIT]  = r_q.ovr;
            end
            RA_DIV:  reg_rdata = BYTE_W'(r_q.div);
            default: reg_rdata[0] = r_q.sel;
        endcase
    end

    assign spi_cs_n = ~r_q.sel;

    sdspi_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .en(busy), .half(r_q.div), .tick(tick)
    );

    sdspi_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(reg_wdata),
        .tick(tick), .miso(spi_miso), .busy(busy), .sck(spi_sck),
        .mosi(spi_mosi), .rx_byte(rx_byte)
    );
endmodule

module sdspi_xfer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] reg_addr,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic       spi_sck,
    input logic       spi_mosi,
    input logic       spi_cs_n,
    input logic       busy,
    input logic       ovr
);
    a_r1_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && !busy) |=> busy);

    a_r4_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !spi_sck);

    a_r3_mosi_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(spi_mosi)) |-> $fell(spi_sck));

    a_r7_cs_follows_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd3) |=> (spi_cs_n == !$past(reg_wdata[0])));

    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !(reg_wr && reg_addr == 2'd1 && reg_wdata[6])) |=> ovr);

    a_r8_busy_write_sets_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && busy) |=> ovr);
endmodule

bind sdspi_xfer sdspi_xfer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .busy(busy), .ovr(r_q.ovr)
);

// File: tb/sdspi_xfer_bench.sv
`timescale 1ns/1ps
module sdspi_xfer_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic spi_sck, spi_mosi, spi_miso, spi_cs_n;

    int n_tests = 0;
    int n_fail = 0;

    logic [7:0] slave_sh = 8'd0;
    logic [7:0] mosi_cap = 8'd0;
    int rise_cnt = 0;

    always #2 clk = ~clk;

    sdspi_xfer u_sdspi_xfer (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    // card model: mode 0, shifts on SCK fall, first bit valid before first rise
    assign spi_miso = slave_sh[7];
    always @(negedge spi_sck) slave_sh <= {slave_sh[6:0], 1'b0};
    always @(posedge spi_sck) begin
        mosi_cap <= {mosi_cap[6:0], spi_mosi};
        rise_cnt <= rise_cnt + 1;
    end

    // {divider, tx byte, card reply}
    localparam logic [23:0] VEC [6] = '{
        {8'd0, 8'hA5, 8'h3C},
        {8'd1, 8'hFF, 8'h00},
        {8'd3, 8'h00, 8'hFF},
        {8'd2, 8'h80, 8'h01},
        {8'd7, 8'h01, 8'h80},
        {8'd5, 8'h5A, 8'hC3}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic arm(input logic [7:0] reply);
        slave_sh = reply; mosi_cap = 8'd0; rise_cnt = 0;
    endtask

    // starts at a negedge; runs one byte; checks R1,R2,R3,R4,R5
    task automatic run_byte(input int d, input logic [7:0] tx, input logic [7:0] rx,
                            input string tag);
        logic [7:0] v;
        arm(rx);
        reg_write(2'd0, tx);
        reg_read(2'd1, v);
        check(v[7] == 1'b1, {tag, " R1 busy set"}, v, 8'h80);
        repeat (16 * (d + 1) - 1) @(negedge clk);
        reg_read(2'd1, v);
        check(v[7] == 1'b1, {tag, " R2 busy before end"}, v[7], 1);
        @(negedge clk);
        reg_read(2'd1, v);
        check(v[7] == 1'b0, {tag, " R2 busy cleared"}, v[7], 0);
        check(mosi_cap == tx, {tag, " R3 mosi msb first"}, mosi_cap, tx);
        check(rise_cnt == 8 && !spi_sck, {tag, " R4 eight rises idle low"}, rise_cnt, 8);
        reg_read(2'd0, v);
        check(v == rx, {tag, " R5 readback"}, v, rx);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        reg_read(2'd1, v); check(v == 8'h00, "R10 status", v, 0);
        reg_read(2'd0, v); check(v == 8'h00, "R10 data", v, 0);
        check(!spi_sck, "R10 sck low", spi_sck, 0);
        reg_read(2'd2, v); check(v == 8'hFF, "R6 reset divider", v, 8'hFF);
        check(spi_cs_n == 1'b1, "R7 reset cs_n", spi_cs_n, 1);

        // R6 transfer at reset divider
        run_byte(255, 8'hC6, 8'h9D, "R6 slowest");

        // table
        for (int i = 0; i < 6; i++) begin
            reg_write(2'd2, VEC[i][23:16]);
            reg_read(2'd2, v);
            check(v == VEC[i][23:16], "R6 divider write", v, VEC[i][23:16]);
            run_byte(int'(VEC[i][23:16]), VEC[i][15:8], VEC[i][7:0], "vec");
        end

        // R8 overrun: second write mid-byte dropped
        reg_write(2'd2, 8'd3);
        arm(8'h77);
        reg_write(2'd0, 8'h96);
        repeat (5) @(negedge clk);
        reg_write(2'd0, 8'h11);
        reg_read(2'd1, v);
        check(v == 8'hC0, "R8 overrun while busy", v, 8'hC0);
        repeat (16 * 4 - 1 - 6) @(negedge clk);
        reg_read(2'd1, v);
        check(v[7] == 1'b1, "R8 timing unchanged before end", v[7], 1);
        @(negedge clk);
        reg_read(2'd1, v);
        check(v == 8'h40, "R8 ends on time, flag sticky", v, 8'h40);
        check(mosi_cap == 8'h96, "R8 first byte kept", mosi_cap, 8'h96);
        reg_read(2'd0, v);
        check(v == 8'h77, "R8 readback intact", v, 8'h77);
        reg_write(2'd1, 8'h00);
        reg_read(2'd1, v);
        check(v == 8'h40, "R8 sticky after plain status write", v, 8'h40);
        reg_write(2'd1, 8'h40);
        reg_read(2'd1, v);
        check(v == 8'h00, "R9 overrun cleared", v, 0);

        // R7 chip select mid-transfer
        arm(8'h00);
        reg_write(2'd0, 8'h3C);
        reg_write(2'd3, 8'h01);
        check(spi_cs_n == 1'b0, "R7 cs asserted mid-byte", spi_cs_n, 0);
        reg_read(2'd1, v);
        check(v[7] == 1'b1, "R7 transfer unaffected", v[7], 1);
        reg_write(2'd3, 8'h00);
        check(spi_cs_n == 1'b1, "R7 cs released", spi_cs_n, 1);
        repeat (80) @(negedge clk);
        check(mosi_cap == 8'h3C, "R7 byte still sent", mosi_cap, 8'h3C);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule